// File: doc/BRIEF.md
# Fine Window Alignment Controller

This block finishes the synchronization calibration once a coarse delay search has already placed the returning photon somewhere inside the 3 ns detection window. It walks two receive channels in strict sequence and, for each, trims a 10-bit fine delay one step (10 ps) at a time until the photon sits at the leading edge of the window. Each trial opens on a rising edge of the shared photon pulse and closes when the channel's valid feedback rises or a 60-clock timeout expires.

A run of consecutive hits with the channel's wanted-position flag still low moves the delay one step later. A run of consecutive misses after at least one forward step means the window edge was crossed, so the delay is pulled back one step and the channel stops there. A run of hits with the wanted-position flag high stops the channel with no further change. Every delay change is presented together with a latch strobe that lasts a fixed number of clocks. When the last channel has stopped, mix-enable falls and sync-end rises, and both stay that way until reset.

Top module: `fine_align_ctrl`

## Requirements
- R1: Channel 0 responds to no photon or valid input until `coarse_done_i` is high; channel 1 responds to none until channel 0 has stopped, so no channel 1 strobe is ever seen before the last channel 0 strobe.
- R2: A trial opens on the clock edge at which `photon_i` is first sampled high. It is a hit when the channel's `valid_i` bit is first sampled high on any of the 1st to 60th following edges, including the 60th, where the timeout also expires (the hit wins). A rise first sampled on the 61st edge or later is a miss.
- R3: Hits and misses are counted as runs: a hit clears the miss run, and a miss clears the hit run. Five hits in a row with `at_edge_i` low move the delay up by one. Five hits in a row with `at_edge_i` high stop the channel with no write.
- R4: Five misses in a row after at least one upward step move the delay down by one, and the channel then stops.
- R5: Five misses in a row before any upward step leave the delay unchanged and produce no strobe. Counting then restarts.
- R6: Each delay change appears on `dly_o` in the first cycle of the channel's `dly_wr_o` bit, and that bit stays high for exactly 3 cycles per change.
- R7: When five hits arrive with the delay at its all-ones maximum and `at_edge_i` low, the channel stops at the maximum with no write.
- R8: A delay only ever changes by exactly one count, and it holds its value after its channel stops.
- R9: `mix_en_o` is high and `sync_end_o` is low from reset until both channels have stopped. After that, `sync_end_o` is high and `mix_en_o` is low, and both hold until reset.
- R10: While reset is asserted and right after it, both delays read 0 and both strobes are low. Channel `c` uses bits `[c*DLY_W +: DLY_W]` of `dly_o`, and bit `c` of `valid_i`, `at_edge_i` and `dly_wr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coarse_done_i | input | 1 | Coarse search finished, level |
| photon_i | input | 1 | Photon pulse shared by both channels |
| valid_i | input | NCH | Per-channel valid feedback |
| at_edge_i | input | NCH | Per-channel wanted-position flag |
| dly_o | output | NCH*DLY_W | Fine delay words, channel 0 in the low field |
| dly_wr_o | output | NCH | Per-channel delay latch strobe |
| mix_en_o | output | 1 | High while calibration is in progress |
| sync_end_o | output | 1 | Calibration complete |

## Verification
The two functions that can fall into the same cycle are the hit detector and the observation timeout: a valid rise first sampled on the 60th edge after the photon edge lands in the cycle where the timer expires. The bench provokes this with a valid pulse placed on exactly that edge, after four hits and one valid pulse placed one edge too late. The boundary is judged at the delay output: the late pulse must count as a miss and break the run, and the on-time pulse must count as the fifth hit of a new run and produce a step. Table-driven runs then compare the final delays and strobe counts against values computed from each channel's window limit and wanted position.

// File: rtl/fwa_pkg.sv
`timescale 1ns/1ps
package fwa_pkg;
  typedef enum logic [2:0] {
    CH_IDLE,
    CH_WAIT,
    CH_OBS,
    CH_EVAL,
    CH_WR,
    CH_DONE
  } ch_state_e;
endpackage

// File: rtl/fwa_edge.sv
`timescale 1ns/1ps
module fwa_edge #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/fwa_chan.sv
`timescale 1ns/1ps
module fwa_chan
  import fwa_pkg::*;
#(
  parameter int DLY_W  = 10,
  parameter int HIT_N  = 5,
  parameter int MISS_N = 5,
  parameter int TMO    = 60,
  parameter int WR_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             photon_rise_i,
  input  logic             valid_i,
  input  logic             at_edge_i,
  output logic [DLY_W-1:0] dly_o,
  output logic             wr_o,
  output logic             done_o
);
  localparam int RUN_MAX = (HIT_N > MISS_N) ? HIT_N : MISS_N;
  localparam int CNT_W   = $clog2(RUN_MAX + 1);
  localparam int TMR_W   = $clog2(TMO + 1);
  localparam int WRC_W   = $clog2(WR_CYC + 1);
  localparam logic [DLY_W-1:0] DMAX = {DLY_W{1'b1}};

  ch_state_e        state_q;
  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] hit_q, miss_q;
  logic [WRC_W-1:0] wcnt_q;
  logic [DLY_W-1:0] dly_q;
  logic             started_q, fin_q;
  logic             v_rise;

  fwa_edge #(.W(1)) u_vedge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (valid_i),
    .rise_o (v_rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CH_IDLE;
      tmr_q     <= '0;
      hit_q     <= '0;
      miss_q    <= '0;
      wcnt_q    <= '0;
      dly_q     <= '0;
      started_q <= 1'b0;
      fin_q     <= 1'b0;
    end else begin
      case (state_q)
        CH_IDLE: if (go_i) state_q <= CH_WAIT;
        CH_WAIT: if (photon_rise_i) begin
          tmr_q   <= '0;
          state_q <= CH_OBS;
        end
        CH_OBS: begin
          // a valid rise wins over a timeout in the same cycle
          if (v_rise) begin
            hit_q   <= hit_q + 1'b1;
            miss_q  <= '0;
            state_q <= CH_EVAL;
          end else if (tmr_q == TMR_W'(TMO - 1)) begin
            miss_q  <= miss_q + 1'b1;
            hit_q   <= '0;
            state_q <= CH_EVAL;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        CH_EVAL: begin
          state_q <= CH_WAIT;
          if (hit_q == CNT_W'(HIT_N)) begin
            if (at_edge_i || dly_q == DMAX) begin
              state_q <= CH_DONE;
            end else begin
              dly_q     <= dly_q + 1'b1;
              started_q <= 1'b1;
              fin_q     <= 1'b0;
              hit_q     <= '0;
              miss_q    <= '0;
              wcnt_q    <= '0;
              state_q   <= CH_WR;
            end
          end else if (miss_q == CNT_W'(MISS_N)) begin
            hit_q  <= '0;
            miss_q <= '0;
            // misses before any forward step are not an edge crossing
            if (started_q) begin
              dly_q   <= dly_q - 1'b1;
              fin_q   <= 1'b1;
              wcnt_q  <= '0;
              state_q <= CH_WR;
            end
          end
        end
        CH_WR: begin
          if (wcnt_q == WRC_W'(WR_CYC - 1)) state_q <= fin_q ? CH_DONE : CH_WAIT;
          else                              wcnt_q  <= wcnt_q + 1'b1;
        end
        CH_DONE: state_q <= CH_DONE;
        default: state_q <= CH_IDLE;
      endcase
    end
  end

  assign dly_o  = dly_q;
  assign wr_o   = (state_q == CH_WR);
  assign done_o = (state_q == CH_DONE);

  // strobe run length, observed independently of the write counter
  logic [WRC_W:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= '0;
    else if (wr_o) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  a_r6_strobe_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_o) |-> (run_q == (WRC_W+1)'(WR_CYC)));

  a_r6_change_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q != $past(dly_q)) |-> wr_o);

  a_r8_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q != $past(dly_q)) |->
      (dly_q == DLY_W'($past(dly_q) + 1'b1) || dly_q == DLY_W'($past(dly_q) - 1'b1)));

  a_r8_hold_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(dly_q)));

  a_r1_idle_until_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_IDLE && !go_i) |=> (state_q == CH_IDLE));
endmodule

// File: rtl/fwa_handshake.sv
`timescale 1ns/1ps
module fwa_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic all_done_i,
  output logic mix_en_o,
  output logic sync_end_o
);
  logic mix_q, end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mix_q <= 1'b1;
      end_q <= 1'b0;
    end else if (all_done_i) begin
      mix_q <= 1'b0;
      end_q <= 1'b1;
    end
  end

  assign mix_en_o   = mix_q;
  assign sync_end_o = end_q;

  a_r9_end_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_end_o |-> !mix_en_o);

  a_r9_end_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_end_o |=> sync_end_o);
endmodule

// File: rtl/fine_align_ctrl.sv
`timescale 1ns/1ps
module fine_align_ctrl #(
  parameter int NCH    = 2,
  parameter int DLY_W  = 10,
  parameter int HIT_N  = 5,
  parameter int MISS_N = 5,
  parameter int TMO    = 60,
  parameter int WR_CYC = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 coarse_done_i,
  input  logic                 photon_i,
  input  logic [NCH-1:0]       valid_i,
  input  logic [NCH-1:0]       at_edge_i,
  output logic [NCH*DLY_W-1:0] dly_o,
  output logic [NCH-1:0]       dly_wr_o,
  output logic                 mix_en_o,
  output logic                 sync_end_o
);
  logic [NCH-1:0] done_w;
  logic [NCH-1:0] go_w;
  logic           ph_rise;

  fwa_edge #(.W(1)) u_ph_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (photon_i),
    .rise_o (ph_rise)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g == 0) begin : g_first
      assign go_w[g] = coarse_done_i;
    end else begin : g_next
      assign go_w[g] = done_w[g-1];
    end

    fwa_chan #(
      .DLY_W  (DLY_W),
      .HIT_N  (HIT_N),
      .MISS_N (MISS_N),
      .TMO    (TMO),
      .WR_CYC (WR_CYC)
    ) u_chan (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .go_i          (go_w[g]),
      .photon_rise_i (ph_rise),
      .valid_i       (valid_i[g]),
      .at_edge_i     (at_edge_i[g]),
      .dly_o         (dly_o[g*DLY_W +: DLY_W]),
      .wr_o          (dly_wr_o[g]),
      .done_o        (done_w[g])
    );

    if (g > 0) begin : g_order
      a_r1_chain_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dly_wr_o[g] |-> done_w[g-1]);
    end
  end

  fwa_handshake u_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .all_done_i (&done_w),
    .mix_en_o   (mix_en_o),
    .sync_end_o (sync_end_o)
  );

  a_r9_end_needs_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_end_o) |-> $past(&done_w));
endmodule

// File: tb/fine_align_ctrl_tb.sv
`timescale 1ns/1ps
module fine_align_ctrl_tb_top;
  localparam int NCH  = 2;
  localparam int DW   = 4;
  localparam int MAXV = (1 << DW) - 1;
  localparam int NSCN = 5;
  // want0, lim0, want1, lim1 : hit while delay <= lim, wanted position at delay == want
  localparam int SCN [NSCN][4] = '{
    '{3, 6, 1, 4},
    '{8, 4, 2, 9},
    '{0, 5, 5, 2},
    '{20, 30, 0, 0},
    '{6, 6, 3, 0}
  };

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            coarse_done = 1'b0;
  logic            photon = 1'b0;
  logic [NCH-1:0]  valid = '0;
  logic [NCH-1:0]  at_edge;
  logic [NCH*DW-1:0] dly;
  logic [NCH-1:0]  dly_wr;
  logic            mix_en, sync_end;

  int want0 = 99, want1 = 99;
  int checks = 0, fails = 0;
  int rises [NCH];
  int highs [NCH];
  int last_wr0, first_wr1, cyc;
  logic [NCH-1:0] wr_prev;

  always #2 clk = ~clk;

  assign at_edge[0] = (int'(dly[DW-1:0]) == want0);
  assign at_edge[1] = (int'(dly[2*DW-1:DW]) == want1);

  fine_align_ctrl #(.NCH(NCH), .DLY_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .coarse_done_i(coarse_done), .photon_i(photon),
    .valid_i(valid), .at_edge_i(at_edge), .dly_o(dly), .dly_wr_o(dly_wr),
    .mix_en_o(mix_en), .sync_end_o(sync_end)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int c = 0; c < NCH; c++) begin
      if (dly_wr[c]) highs[c] <= highs[c] + 1;
      if (dly_wr[c] && !wr_prev[c]) rises[c] <= rises[c] + 1;
    end
    if (dly_wr[0]) last_wr0 <= cyc;
    if (dly_wr[1] && first_wr1 < 0) first_wr1 <= cyc;
    wr_prev <= dly_wr;
  end

  function automatic int d(int c);
    return int'(dly[c*DW +: DW]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    photon = 1'b0;
    valid  = '0;
    repeat (3) @(posedge clk);
    #1;
    for (int c = 0; c < NCH; c++) begin rises[c] = 0; highs[c] = 0; end
    last_wr0 = -1; first_wr1 = -1; wr_prev = '0; cyc = 0;
    rst_ni = 1'b1;
    @(posedge clk); #1;
  endtask

  // one trial: k = edge after the photon edge at which valid is first high, 0 = none
  task automatic obs(int k0, int k1);
    photon = 1'b1;
    @(posedge clk); #1;
    photon = 1'b0;
    for (int t = 1; t < 75; t++) begin
      valid[0] = (k0 == t);
      valid[1] = (k1 == t);
      @(posedge clk); #1;
    end
    valid = '0;
  endtask

  task automatic obs_model(int lim0, int lim1);
    obs((d(0) <= lim0) ? 5 : 0, (d(1) <= lim1) ? 5 : 0);
  endtask

  function automatic void predict(int want, int lim, output int fin, output int wrs);
    if (want <= lim && want <= MAXV) begin fin = want; wrs = want; end
    else if (lim < MAXV)             begin fin = lim;  wrs = lim + 2; end
    else                             begin fin = MAXV; wrs = MAXV; end
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int f0, w0, f1, w1;
    do_reset();
    // R10 reset state, R9 handshake idle levels
    chk("R10 dly0 after reset", d(0), 0);
    chk("R10 dly1 after reset", d(1), 0);
    chk("R10 strobes after reset", int'(dly_wr), 0);
    chk("R9 mix_en after reset", int'(mix_en), 1);
    chk("R9 sync_end after reset", int'(sync_end), 0);

    // R1: no coarse_done -> both channels ignore hits
    coarse_done = 1'b0;
    for (int i = 0; i < 8; i++) obs(5, 5);
    chk("R1 dly0 without coarse_done", d(0), 0);
    chk("R1 dly1 without coarse_done", d(1), 0);
    chk("R1 no strobe without coarse_done", rises[0] + rises[1], 0);

    // table: full runs with computed final values
    for (int s = 0; s < NSCN; s++) begin
      int n;
      do_reset();
      want0 = SCN[s][0];
      want1 = SCN[s][2];
      coarse_done = 1'b1;
      n = 0;
      while (!sync_end && n < 400) begin
        obs_model(SCN[s][1], SCN[s][3]);
        n++;
      end
      predict(SCN[s][0], SCN[s][1], f0, w0);
      predict(SCN[s][2], SCN[s][3], f1, w1);
      // R3/R4/R7 final position
      chk($sformatf("R3 R4 R7 scn%0d dly0", s), d(0), f0);
      chk($sformatf("R3 R4 R7 scn%0d dly1", s), d(1), f1);
      chk($sformatf("R8 scn%0d writes ch0", s), rises[0], w0);
      chk($sformatf("R8 scn%0d writes ch1", s), rises[1], w1);
      chk($sformatf("R6 scn%0d strobe cycles ch0", s), highs[0], 3 * rises[0]);
      chk($sformatf("R6 scn%0d strobe cycles ch1", s), highs[1], 3 * rises[1]);
      if (first_wr1 >= 0 && last_wr0 >= 0)
        chk($sformatf("R1 scn%0d ch1 after ch0", s), int'(first_wr1 > last_wr0), 1);
      chk($sformatf("R9 scn%0d sync_end", s), int'(sync_end), 1);
      chk($sformatf("R9 scn%0d mix_en", s), int'(mix_en), 0);
      // R8 hold after finish
      want0 = 99; want1 = 99;
      for (int i = 0; i < 6; i++) obs(5, 5);
      chk($sformatf("R8 scn%0d dly0 held", s), d(0), f0);
      chk($sformatf("R8 scn%0d dly1 held", s), d(1), f1);
      chk($sformatf("R9 scn%0d sync_end held", s), int'(sync_end), 1);
    end

    // R2/R3 boundary: late rise is a miss that breaks the run; 60th edge is a hit
    do_reset();
    want0 = 99; want1 = 99;
    coarse_done = 1'b1;
    for (int i = 0; i < 4; i++) obs(5, 0);
    obs(61, 0);
    for (int i = 0; i < 4; i++) obs(5, 0);
    chk("R2 R3 late valid breaks hit run", d(0), 0);
    obs(60, 0);
    chk("R2 valid on timeout edge is a hit", d(0), 1);
    chk("R6 one strobe for one step", rises[0], 1);

    // R5: misses before any step are not an edge crossing
    do_reset();
    coarse_done = 1'b1;
    for (int i = 0; i < 5; i++) obs(0, 0);
    chk("R5 dly0 unchanged after early misses", d(0), 0);
    chk("R5 no strobe after early misses", rises[0], 0);
    for (int i = 0; i < 5; i++) obs(5, 0);
    chk("R5 stepping resumes after early misses", d(0), 1);
    chk("R9 not finished mid calibration", int'(sync_end), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule